// File: doc/BRIEF.md
# Transaction-Gated Bus Clock Generator

This block drives the clock pin of a general-purpose parallel bus. The pin runs at half the internal clock rate. Each bus cycle lasts two internal clocks: a high half, then a low half. The rising edge of the bus clock ends one bus cycle and starts the next.

When the interface is enabled and gating is off, the clock runs continuously. When gating is on, the clock rests high. It toggles only in bus cycles that belong to a transaction. The bus sequencer supplies three signals: the read strobe, the write strobe, and a look-ahead flag called `wr_next`. This flag says that the write strobe will assert in the following bus cycle.

Timing of the inputs:
- The block samples the strobe inputs on the internal clock edge that ends a high half. At that edge it decides whether the low half that follows is driven low.
- After `en` is first sampled high, these decision edges are the 1st, 3rd, 5th and later internal edges.
- The strobes must be stable across each decision edge.

Top module: `gated_bus_clk`

## Requirements
- R1: While `en` is low, `bus_clk` is high and `clk_run` is low from the next internal clock edge onward. The strobes, `gate` and `wr2cyc` have no effect while `en` is low.
- R2: With `en` high and `gate` low, `bus_clk` is low in every low half and high in every high half. The first low half starts at the first edge at which `en` is sampled high.
- R3: With `gate` high and no strobe or qualifying look-ahead, `bus_clk` stays high.
- R4: With `gate` high, `bus_clk` goes low in every bus cycle in which `rd_strb` is 1 at the decision edge. This holds for both values of `wr2cyc`.
- R5: With `gate` high and `wr2cyc` = 1, `bus_clk` goes low in exactly the bus cycles in which `wr_strb` is 1.
- R6: With `gate` high and `wr2cyc` = 0, `bus_clk` also goes low in the bus cycle in which `wr_next` is 1. Because the sequencer raises `wr_next` one cycle ahead of the write strobe, the clock starts one bus cycle before the write strobe.
- R7: The last falling edge of a gated burst is in the final strobe cycle. The rising edge that ends that cycle is the last edge, and the next cycle with no strobe stays high.
- R8: Every low phase of `bus_clk` lasts exactly one internal clock. A fall happens only at a decision edge. A change of `gate` or `en` during a low half never shortens the low half or adds an extra edge.
- R9: `clk_run` is high in every internal cycle in which `bus_clk` is low, and in the high half that follows it. `clk_run` is therefore high for two internal clocks per clock pulse and low otherwise.
- R10: With `wr2cyc` = 1, `wr_next` has no effect on `bus_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Interface enable |
| gate | input | 1 | 1 = clock only during transactions |
| wr2cyc | input | 1 | 1 = two-cycle write strobe timing |
| rd_strb | input | 1 | Read strobe level for the current bus cycle |
| wr_strb | input | 1 | Write strobe level for the current bus cycle |
| wr_next | input | 1 | Write strobe asserts in the next bus cycle |
| bus_clk | output | 1 | Bus clock pin, registered |
| clk_run | output | 1 | Bus clock is toggling |

## Verification
The bench drives 16-cycle strobe patterns, one bus cycle at a time, and checks both halves of every cycle. The patterns are:
- Continuous running, which separates free running from gating.
- An idle gated run, which shows that gating holds the pin.
- A read burst.
- A write burst under each `wr2cyc` setting, with the same `wr_next` pulse in both. This isolates the one-cycle early start and shows that the look-ahead is ignored in two-cycle mode.
- Back-to-back read and write bursts, which check that the stop point follows each strobe release.

Separate runs change `gate` and `en` in the middle of a low half, and strobes are driven while the interface is disabled. These runs check that pulse width is preserved and that the pin is forced high.

// File: rtl/gated_bus_clk.sv
module gated_bus_clk (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic gate,
  input  logic wr2cyc,
  input  logic rd_strb,
  input  logic wr_strb,
  input  logic wr_next,
  output logic bus_clk,
  output logic clk_run
);

  logic hi_half_q;
  logic run_q;
  logic bclk_q;
  logic want_run;

  assign want_run = !gate || rd_strb || wr_strb || (!wr2cyc && wr_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_half_q <= 1'b1;
      run_q     <= 1'b0;
      bclk_q    <= 1'b1;
    end else if (!en) begin
      hi_half_q <= 1'b1;
      run_q     <= 1'b0;
      bclk_q    <= 1'b1;
    end else begin
      hi_half_q <= !hi_half_q;
      if (hi_half_q) begin
        run_q  <= want_run;
        bclk_q <= !want_run;
      end else begin
        bclk_q <= 1'b1;
      end
    end
  end

  assign bus_clk = bclk_q;
  assign clk_run = run_q;

  // R1
  disabled_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (bus_clk && !clk_run));

  // R2
  free_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !gate && hi_half_q) |=> !bus_clk);

  // R3
  gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gate && !rd_strb && !wr_strb && (wr2cyc || !wr_next)) |=> bus_clk);

  // R8
  low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clk |=> bus_clk);

  // R8
  fall_at_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_clk) |-> $past(en && hi_half_q));

  // R9
  run_covers_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clk |-> clk_run);

endmodule

// File: tb/sim_gated_bus_clk.sv
module sim_gated_bus_clk;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, gate = 1'b0, wr2cyc = 1'b0;
  logic rd_strb = 1'b0, wr_strb = 1'b0, wr_next = 1'b0;
  logic bus_clk, clk_run;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  gated_bus_clk u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .gate(gate), .wr2cyc(wr2cyc),
    .rd_strb(rd_strb), .wr_strb(wr_strb), .wr_next(wr_next),
    .bus_clk(bus_clk), .clk_run(clk_run)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic go_disabled();
    @(negedge clk);
    en = 1'b0; rd_strb = 1'b0; wr_strb = 1'b0; wr_next = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Bit k of each pattern is bus cycle k after enable; exp gives the cycles whose low half is driven low.
  task automatic run_pattern(input string req, input logic g, input logic w2,
                             input logic [15:0] rdp, input logic [15:0] wrp,
                             input logic [15:0] nxp, input logic [15:0] exp);
    go_disabled();
    gate = g; wr2cyc = w2; en = 1'b1;
    for (int k = 0; k < 16; k++) begin
      rd_strb = rdp[k]; wr_strb = wrp[k]; wr_next = nxp[k];
      @(posedge clk);
      @(negedge clk);
      check(req, bus_clk, !exp[k], $sformatf("bus_clk low half cycle %0d", k));
      check("R9", clk_run, exp[k], $sformatf("clk_run low half cycle %0d", k));
      @(posedge clk);
      @(negedge clk);
      check(req, bus_clk, 1'b1, $sformatf("bus_clk high half after cycle %0d", k));
      check("R9", clk_run, exp[k], $sformatf("clk_run high half after cycle %0d", k));
    end
  endtask

  task automatic t_reset();
    check("R1", bus_clk, 1'b1, "bus_clk in reset");
    check("R1", clk_run, 1'b0, "clk_run in reset");
  endtask

  task automatic t_disabled();
    go_disabled();
    gate = 1'b0; wr2cyc = 1'b0; rd_strb = 1'b1; wr_strb = 1'b1; wr_next = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R1", bus_clk, 1'b1, "bus_clk while disabled");
      check("R1", clk_run, 1'b0, "clk_run while disabled");
    end
    rd_strb = 1'b0; wr_strb = 1'b0; wr_next = 1'b0;
  endtask

  task automatic t_midlow_change(input bit use_en);
    go_disabled();
    gate = 1'b0; wr2cyc = 1'b1; en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8", bus_clk, 1'b0, "low half before change");
    if (use_en) en = 1'b0; else gate = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8", bus_clk, 1'b1, "rise after one-clock low");
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R8", bus_clk, 1'b1, "no edge after change");
      check("R9", clk_run, 1'b0, "clk_run after change");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    rst_n = 1'b1;
    t_disabled();
    // R2 free running
    run_pattern("R2", 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF);
    // R3 gated idle
    run_pattern("R3", 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    // R4 read, both timing settings; R7 stop after release
    run_pattern("R4", 1'b1, 1'b0, 16'h0070, 16'h0000, 16'h0000, 16'h0070);
    run_pattern("R4", 1'b1, 1'b1, 16'h0070, 16'h0000, 16'h0000, 16'h0070);
    // R5 and R10: two-cycle write ignores look-ahead
    run_pattern("R5", 1'b1, 1'b1, 16'h0000, 16'h0018, 16'h0004, 16'h0018);
    run_pattern("R10", 1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0404, 16'h0000);
    // R6 single-cycle write starts a cycle early
    run_pattern("R6", 1'b1, 1'b0, 16'h0000, 16'h0018, 16'h0004, 16'h001C);
    // R7 back-to-back read then write with gaps
    run_pattern("R7", 1'b1, 1'b0, 16'h0006, 16'h0600, 16'h0100, 16'h0706);
    t_midlow_change(1'b0);
    t_midlow_change(1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule